// File: doc/BRIEF.md
# Segment Address Translation Unit

This block turns a segmented memory reference into a 32-bit linear address. It keeps six cached segment descriptors, one for each segment register. Each descriptor holds a 16-bit selector, a 32-bit base, a 32-bit limit and a 4-bit rights field. A write port loads a descriptor into one register slot. Each request names a slot, a 32-bit effective address, an access kind, an access size and the current privilege level.

In the same cycle the block forms the wrapped sum of base and effective address. It also runs three checks: privilege, segment type and limit. The result is registered and appears one cycle after the request. A request that fails any check produces a typed fault code and a linear address of zero. Loading descriptors from memory, paging and fault handling belong to other blocks.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset `rspValid` is 0 and every descriptor is cleared. A request through any slot therefore returns fault 2 (not present).
- R2: `rspValid` is 1 in exactly the cycle after a cycle with `reqValid` high, and 0 after a cycle with `reqValid` low.
- R3: With no fault, `rspLinear` equals descriptor base plus `reqEa`, taken modulo 2^32, and `rspFault` is 0.
- R4: Fault 1 (limit) is raised when `reqEa` plus the size in bytes minus one exceeds the limit. The comparison is 33 bits wide, so a carry out of bit 31 counts as exceeding. Size codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes.
- R5: A write (`reqKind` 1) to a code segment (rights bit 2 set) gives fault 2 (type).
- R6: A fetch (`reqKind` 2) from a data segment (rights bit 2 clear) gives fault 2. A read (`reqKind` 0, with 3 treated as a read) of a code segment is allowed.
- R7: When `reqCpl` is numerically greater than the descriptor privilege level in rights bits 1:0, the fault is 3 (privilege).
- R8: When several checks fail, privilege wins over type, and type wins over limit.
- R9: A descriptor whose present bit (rights bit 3) is clear faults every access with fault 2.
- R10: Whenever `rspFault` is non-zero, `rspLinear` is 0.
- R11: A descriptor load takes effect from the next request. A request in the same cycle as the load uses the old contents.
- R12: `rspSel` returns the selector held in the slot the request named.
- R13: A load to a slot index of 6 or more is ignored. A request naming such a slot gives fault 2 and selector 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| loadEn | input | 1 | Descriptor load strobe |
| loadIdx | input | 3 | Slot to load |
| loadSel | input | 16 | Selector to store |
| loadBase | input | 32 | Segment base |
| loadLimit | input | 32 | Segment limit (highest valid offset) |
| loadRights | input | 4 | {present, isCode, dpl[1:0]} |
| reqValid | input | 1 | Request strobe |
| reqSeg | input | 3 | Slot used by the request |
| reqEa | input | 32 | Effective address |
| reqKind | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| reqSize | input | 2 | Size code, giving 1 << code bytes |
| reqCpl | input | 2 | Current privilege level |
| rspValid | output | 1 | Result valid |
| rspLinear | output | 32 | Linear address, or 0 on a fault |
| rspFault | output | 2 | 0 none, 1 limit, 2 type, 3 privilege |
| rspSel | output | 16 | Selector of the slot used |

## Verification
The assertions check four things on every cycle: the one-cycle valid latency, a zero address on every fault, privilege taking priority whenever the requester is outer, and that no fault-free result came from an access running past its limit. Other behaviours appear only in the bench's scenarios. These are the exact wrapped sum, the 33-bit boundary at the top of the address space, the precedence of type over limit, same-cycle load ordering, and ignored out-of-range slots.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int SEL_W  = 16;
  localparam int ADDR_W = 32;
  localparam int PL_W   = 2;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_LIMIT = 2'd1,
    FLT_TYPE  = 2'd2,
    FLT_PRIV  = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } access_e;

  typedef struct packed {
    logic            present;
    logic            isCode;
    logic [PL_W-1:0] dpl;
  } rights_t;

  typedef struct packed {
    logic [SEL_W-1:0]  sel;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] limit;
    rights_t           rights;
  } desc_t;

  typedef struct packed {
    logic captureRsp;
    logic writeDesc;
    logic segInRange;
  } xlStrobe_t;
endpackage

// File: rtl/seg_xlate_ctrl.sv
module seg_xlate_ctrl
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SEG = 6,
  localparam int IDX_W = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadEn,
  input  logic [IDX_W-1:0] loadIdx,
  input  logic             reqValid,
  input  logic [IDX_W-1:0] reqSeg,
  output xlStrobe_t        strobe,
  output logic             rspValid
);
  localparam logic [IDX_W:0] SEG_COUNT = (IDX_W+1)'(NUM_SEG);

  always_comb begin
    strobe.captureRsp = reqValid;
    strobe.writeDesc  = loadEn && ({1'b0, loadIdx} < SEG_COUNT);
    strobe.segInRange = {1'b0, reqSeg} < SEG_COUNT;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= reqValid;
  end

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid); // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid); // R2
endmodule

// File: rtl/seg_xlate_dpath.sv
module seg_xlate_dpath
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SEG = 6,
  localparam int IDX_W = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  xlStrobe_t         strobe,
  input  logic [IDX_W-1:0]  loadIdx,
  input  desc_t             newDesc,
  input  logic [IDX_W-1:0]  reqSeg,
  input  logic [ADDR_W-1:0] reqEa,
  input  access_e           reqKind,
  input  logic [1:0]        reqSize,
  input  logic [PL_W-1:0]   reqCpl,
  output logic [ADDR_W-1:0] rspLinear,
  output fault_e            rspFault,
  output logic [SEL_W-1:0]  rspSel
);
  desc_t descTab [NUM_SEG];

  for (genvar g = 0; g < NUM_SEG; g++) begin : gEntry
    desc_t entryQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) entryQ <= '0;
      else if (strobe.writeDesc && loadIdx == IDX_W'(g)) entryQ <= newDesc;
    end
    assign descTab[g] = entryQ;
  end

  desc_t curDesc;
  always_comb begin
    curDesc = '0;
    for (int i = 0; i < NUM_SEG; i++)
      if (strobe.segInRange && reqSeg == IDX_W'(i)) curDesc = descTab[i];
  end

  logic [ADDR_W:0]   spanM1;
  logic [ADDR_W:0]   lastByte;
  logic [ADDR_W-1:0] sumAddr;
  logic              privBad, typeBad, limitBad;
  fault_e            nextFault;

  always_comb begin
    spanM1   = ({{ADDR_W{1'b0}}, 1'b1} << reqSize) - 1'b1;
    lastByte = {1'b0, reqEa} + spanM1;
    sumAddr  = curDesc.base + reqEa;
    privBad  = strobe.segInRange && (reqCpl > curDesc.rights.dpl);
    typeBad  = !strobe.segInRange || !curDesc.rights.present
             || (reqKind == ACC_WRITE && curDesc.rights.isCode)
             || (reqKind == ACC_FETCH && !curDesc.rights.isCode);
    limitBad = lastByte > {1'b0, curDesc.limit};
    if (privBad)       nextFault = FLT_PRIV;
    else if (typeBad)  nextFault = FLT_TYPE;
    else if (limitBad) nextFault = FLT_LIMIT;
    else               nextFault = FLT_NONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspLinear <= '0;
      rspFault  <= FLT_NONE;
      rspSel    <= '0;
    end else if (strobe.captureRsp) begin
      rspLinear <= (nextFault == FLT_NONE) ? sumAddr : '0;
      rspFault  <= nextFault;
      rspSel    <= curDesc.sel;
    end
  end

  AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    strobe.captureRsp |=> (rspFault == FLT_NONE || rspLinear == '0)); // R10
  AST_PRIV_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.captureRsp && strobe.segInRange && reqCpl > curDesc.rights.dpl)
    |=> rspFault == FLT_PRIV); // R7
  AST_NONE_IN_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.captureRsp |=> (rspFault != FLT_NONE
      || $past(lastByte) <= $past({1'b0, curDesc.limit}))); // R4
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SEG = 6,
  localparam int IDX_W = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadEn,
  input  logic [IDX_W-1:0]  loadIdx,
  input  logic [SEL_W-1:0]  loadSel,
  input  logic [ADDR_W-1:0] loadBase,
  input  logic [ADDR_W-1:0] loadLimit,
  input  logic [3:0]        loadRights,
  input  logic              reqValid,
  input  logic [IDX_W-1:0]  reqSeg,
  input  logic [ADDR_W-1:0] reqEa,
  input  logic [1:0]        reqKind,
  input  logic [1:0]        reqSize,
  input  logic [PL_W-1:0]   reqCpl,
  output logic              rspValid,
  output logic [ADDR_W-1:0] rspLinear,
  output logic [1:0]        rspFault,
  output logic [SEL_W-1:0]  rspSel
);
  xlStrobe_t strobe;
  desc_t     newDesc;
  fault_e    faultQ;

  assign newDesc = '{sel: loadSel, base: loadBase, limit: loadLimit,
                     rights: rights_t'(loadRights)};
  assign rspFault = faultQ;

  seg_xlate_ctrl #(.NUM_SEG(NUM_SEG)) uCtrl (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadIdx(loadIdx),
    .reqValid(reqValid), .reqSeg(reqSeg), .strobe(strobe), .rspValid(rspValid)
  );

  seg_xlate_dpath #(.NUM_SEG(NUM_SEG)) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .loadIdx(loadIdx),
    .newDesc(newDesc), .reqSeg(reqSeg), .reqEa(reqEa),
    .reqKind(access_e'(reqKind)), .reqSize(reqSize), .reqCpl(reqCpl),
    .rspLinear(rspLinear), .rspFault(faultQ), .rspSel(rspSel)
  );
endmodule

// File: tb/seg_xlate_unit_test.sv
module seg_xlate_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 18;
  // {seg[2:0], kind[1:0], size[1:0], cpl[1:0], ea[31:0], fault[1:0], linear[31:0]}
  localparam logic [74:0] VEC [NV] = '{
    {3'd0, 2'd0, 2'd2, 2'd3, 32'h0000_0010, 2'd0, 32'h1000_0010}, // R3
    {3'd0, 2'd1, 2'd1, 2'd0, 32'h0000_FFFE, 2'd0, 32'h1000_FFFE}, // R4 edge ok
    {3'd0, 2'd0, 2'd2, 2'd3, 32'h0000_FFFD, 2'd1, 32'h0},         // R4
    {3'd1, 2'd2, 2'd0, 2'd0, 32'h0000_0123, 2'd0, 32'h0040_0123}, // R6
    {3'd1, 2'd1, 2'd0, 2'd0, 32'h0000_0123, 2'd2, 32'h0},         // R5
    {3'd1, 2'd0, 2'd2, 2'd0, 32'h0000_0010, 2'd0, 32'h0040_0010}, // R6 read code
    {3'd1, 2'd2, 2'd0, 2'd3, 32'h0000_0010, 2'd3, 32'h0},         // R7
    {3'd2, 2'd2, 2'd0, 2'd3, 32'h0000_0010, 2'd2, 32'h0},         // R6
    {3'd2, 2'd0, 2'd3, 2'd3, 32'hFFFF_FFF8, 2'd0, 32'hEFFF_FFF8}, // R3 wrap
    {3'd2, 2'd0, 2'd3, 2'd3, 32'hFFFF_FFF9, 2'd1, 32'h0},         // R4 carry
    {3'd3, 2'd0, 2'd0, 2'd0, 32'h0000_0000, 2'd2, 32'h0},         // R9
    {3'd4, 2'd0, 2'd0, 2'd1, 32'h0000_2000, 2'd3, 32'h0},         // R8
    {3'd4, 2'd0, 2'd0, 2'd0, 32'h0000_1000, 2'd1, 32'h0},         // R4
    {3'd4, 2'd1, 2'd2, 2'd0, 32'h0000_0FFC, 2'd0, 32'h0000_2FFC}, // R3
    {3'd5, 2'd0, 2'd0, 2'd0, 32'h0000_0000, 2'd2, 32'h0},         // R9
    {3'd1, 2'd1, 2'd0, 2'd3, 32'h0000_0000, 2'd3, 32'h0},         // R8
    {3'd6, 2'd0, 2'd0, 2'd0, 32'h0000_0000, 2'd2, 32'h0},         // R13
    {3'd4, 2'd1, 2'd2, 2'd0, 32'h0000_0FFD, 2'd1, 32'h0}          // R4
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadEn = 1'b0;
  logic [2:0]  loadIdx = '0;
  logic [15:0] loadSel = '0;
  logic [31:0] loadBase = '0, loadLimit = '0;
  logic [3:0]  loadRights = '0;
  logic        reqValid = 1'b0;
  logic [2:0]  reqSeg = '0;
  logic [31:0] reqEa = '0;
  logic [1:0]  reqKind = '0, reqSize = '0, reqCpl = '0;
  logic        rspValid;
  logic [31:0] rspLinear;
  logic [1:0]  rspFault;
  logic [15:0] rspSel;
  int checks = 0;
  int errors = 0;

  seg_xlate_unit uut (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadIdx(loadIdx),
    .loadSel(loadSel), .loadBase(loadBase), .loadLimit(loadLimit),
    .loadRights(loadRights), .reqValid(reqValid), .reqSeg(reqSeg),
    .reqEa(reqEa), .reqKind(reqKind), .reqSize(reqSize), .reqCpl(reqCpl),
    .rspValid(rspValid), .rspLinear(rspLinear), .rspFault(rspFault),
    .rspSel(rspSel)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic setLoad(input logic [2:0] idx, input logic [15:0] sel,
                         input logic [31:0] base, input logic [31:0] lim,
                         input logic [3:0] rights);
    loadEn = 1'b1; loadIdx = idx; loadSel = sel;
    loadBase = base; loadLimit = lim; loadRights = rights;
  endtask

  task automatic setReq(input logic [2:0] seg, input logic [1:0] kind,
                        input logic [1:0] size, input logic [1:0] cpl,
                        input logic [31:0] ea);
    reqValid = 1'b1; reqSeg = seg; reqKind = kind; reqSize = size;
    reqCpl = cpl; reqEa = ea;
  endtask

  task automatic loadDesc(input logic [2:0] idx, input logic [15:0] sel,
                          input logic [31:0] base, input logic [31:0] lim,
                          input logic [3:0] rights);
    @(negedge clk); setLoad(idx, sel, base, lim, rights);
    @(negedge clk); loadEn = 1'b0;
  endtask

  task automatic doReq(input logic [2:0] seg, input logic [1:0] kind,
                       input logic [1:0] size, input logic [1:0] cpl,
                       input logic [31:0] ea);
    @(negedge clk); setReq(seg, kind, size, cpl, ea);
    @(negedge clk); reqValid = 1'b0;
  endtask

  task automatic finishRun;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rspValid in reset", 32'(rspValid), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 rspValid after reset", 32'(rspValid), 32'd0);
    doReq(3'd0, 2'd0, 2'd0, 2'd0, 32'h0);
    chk("R1 cleared slot fault", 32'(rspFault), 32'd2);
    chk("R1 cleared slot sel", 32'(rspSel), 32'd0);

    loadDesc(3'd0, 16'h0010, 32'h1000_0000, 32'h0000_FFFF, 4'hB);
    loadDesc(3'd1, 16'h0008, 32'h0040_0000, 32'hFFFF_FFFF, 4'hC);
    loadDesc(3'd2, 16'h0023, 32'hF000_0000, 32'hFFFF_FFFF, 4'hB);
    loadDesc(3'd3, 16'h0030, 32'h0000_0100, 32'h0000_FFFF, 4'h3);
    loadDesc(3'd4, 16'h0040, 32'h0000_2000, 32'h0000_0FFF, 4'h8);

    for (int i = 0; i < NV; i++) begin
      doReq(VEC[i][74:72], VEC[i][71:70], VEC[i][69:68], VEC[i][67:66], VEC[i][65:34]);
      chk($sformatf("R2 valid vec %0d", i), 32'(rspValid), 32'd1);
      chk($sformatf("R3-R10 fault vec %0d", i), 32'(rspFault), 32'(VEC[i][33:32]));
      chk($sformatf("R3 R10 linear vec %0d", i), rspLinear, VEC[i][31:0]);
    end

    @(negedge clk);
    chk("R2 no request no valid", 32'(rspValid), 32'd0);

    doReq(3'd2, 2'd0, 2'd0, 2'd3, 32'h4);
    chk("R12 selector slot 2", 32'(rspSel), 32'h0023);

    // R11: load and request to slot 5 in the same cycle
    @(negedge clk);
    setLoad(3'd5, 16'h0055, 32'h0000_5000, 32'h0000_FFFF, 4'hB);
    setReq(3'd5, 2'd0, 2'd0, 2'd0, 32'h4);
    @(negedge clk); loadEn = 1'b0; reqValid = 1'b0;
    chk("R11 same cycle uses old", 32'(rspFault), 32'd2);
    doReq(3'd5, 2'd0, 2'd0, 2'd0, 32'h4);
    chk("R11 next request fault", 32'(rspFault), 32'd0);
    chk("R11 next request linear", rspLinear, 32'h0000_5004);
    chk("R12 selector slot 5", 32'(rspSel), 32'h0055);

    // R13: load to slot 7 ignored
    loadDesc(3'd7, 16'h0077, 32'h0, 32'hFFFF_FFFF, 4'hB);
    doReq(3'd7, 2'd0, 2'd0, 2'd0, 32'h0);
    chk("R13 slot 7 fault", 32'(rspFault), 32'd2);
    chk("R13 slot 7 sel", 32'(rspSel), 32'd0);
    doReq(3'd0, 2'd0, 2'd0, 2'd0, 32'h8);
    chk("R13 slot 0 intact", rspLinear, 32'h1000_0008);

    finishRun();
  end
endmodule